// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel bidirectional ports, A and B, inside a synchronous design. Each port appears as three signals: an input word, an output word and a per-lane output-enable vector. Each direction has a capture register. The A-side word is stored into the A-to-B register on a rising edge of the A-to-B capture strobe. The B-side word is stored into the B-to-A register on a rising edge of the B-to-A capture strobe. Both strobes are sampled on the system clock `clk`. Capture always runs, whatever the drive settings are.

An active-low output enable and a direction input choose which port is driven: port B, port A, or neither (isolation). The driven port receives, lane for lane and without inversion, either the live word from the opposite port or the stored register. A per-direction select input makes that choice. The live path is combinational.

Each strobe has its own small state machine with two states. `EDGE_ARMED` means the strobe was last seen low. `EDGE_SPENT` means it was last seen high, and reset enters this state. Transition ARM_TO_FIRE (`EDGE_ARMED` to `EDGE_SPENT`, strobe high) loads the register in that cycle. Transition SPENT_TO_ARM (`EDGE_SPENT` to `EDGE_ARMED`, strobe low) re-arms the detector. The drive decision is a mode with three values: `DRV_NONE`, `DRV_TO_A` and `DRV_TO_B`.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both stored words are cleared to zero asynchronously, and they read back as zero through the stored-source path after reset.
- R2: At a `clk` rising edge where `cap_ab` is high and was low at the previous sampled edge, `a_in` at that edge is stored into the A-to-B register. It is visible one cycle later.
- R3: At a `clk` rising edge where `cap_ba` is high and was low at the previous sampled edge, `b_in` at that edge is stored into the B-to-A register. It is visible one cycle later.
- R4: A strobe that stays high, or stays low, leaves its register unchanged. This includes a strobe that is already high when reset is released: it stores nothing until it has been seen low.
- R5: With `oe_n` = 1, `a_oe` and `b_oe` are all zeros and `a_out` and `b_out` are zero.
- R6: With `oe_n` = 0 and `dir` = 1, `b_oe` is all ones and `a_oe` is all zeros.
- R7: With `oe_n` = 0 and `dir` = 0, `a_oe` is all ones and `b_oe` is all zeros.
- R8: While B is driven, `b_out` equals `a_in` in the same cycle when `sel_ab` = 0. It equals the stored A-to-B word when `sel_ab` = 1.
- R9: While A is driven, `a_out` equals `b_in` in the same cycle when `sel_ba` = 0. It equals the stored B-to-A word when `sel_ba` = 1.
- R10: Capture works in isolation and in either drive direction, including capture from the port that is currently being driven.
- R11: `a_oe` and `b_oe` are never both nonzero. An output that is not driven reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1 drives port B, 0 drives port A |
| cap_ab | input | 1 | A-to-B capture strobe (rising edge stores) |
| cap_ba | input | 1 | B-to-A capture strobe (rising edge stores) |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored A-to-B |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored B-to-A |
| a_in | input | WIDTH | Word arriving at port A |
| a_out | output | WIDTH | Word driven onto port A |
| a_oe | output | WIDTH | Per-lane drive enable for port A |
| b_in | input | WIDTH | Word arriving at port B |
| b_out | output | WIDTH | Word driven onto port B |
| b_oe | output | WIDTH | Per-lane drive enable for port B |

## Verification
The enables and live-mode outputs are combinational. The bench changes inputs just after a falling clock edge and checks them one time unit later, within the same cycle. A store happens at the first rising edge that sees the strobe high after a low. Its result is checked at the falling edge that follows, so the stored-source output is compared half a cycle after that rising edge. Hold cases first leave the strobe steady across one or more rising edges. Only then is the stored output compared, while the live input meanwhile holds a different value.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        EDGE_ARMED = 1'b0,
        EDGE_SPENT = 1'b1
    } edge_state_t;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_TO_A = 2'd1,
        DRV_TO_B = 2'd2
    } drive_mode_t;

endpackage

// File: rtl/xcvr_edge_fsm.sv
module xcvr_edge_fsm
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fire
);

    edge_state_t state_q;
    edge_state_t state_d;

    // State register: reset lands in SPENT so a strobe high at release is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EDGE_SPENT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_ARMED: if (strobe)  state_d = EDGE_SPENT;  // ARM_TO_FIRE
            EDGE_SPENT: if (!strobe) state_d = EDGE_ARMED;  // SPENT_TO_ARM
            default:                 state_d = EDGE_SPENT;
        endcase
    end

    // Output: load pulse on ARM_TO_FIRE
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            EDGE_ARMED: fire = strobe;
            EDGE_SPENT: fire = 1'b0;
            default:    fire = 1'b0;
        endcase
    end

    // R4
    fire_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !$past(strobe));

endmodule

// File: rtl/xcvr_word_reg.sv
module xcvr_word_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] CLEAR_WORD = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CLEAR_WORD;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             oe_n,
    input  logic             dir,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_oe
);

    localparam logic [WIDTH-1:0] ALL_ON  = '1;
    localparam logic [WIDTH-1:0] ALL_OFF = '0;

    drive_mode_t mode;

    // Mode decision
    always_comb begin
        if (oe_n)     mode = DRV_NONE;
        else if (dir) mode = DRV_TO_B;
        else          mode = DRV_TO_A;
    end

    // Enables replicated from the single decision
    always_comb begin
        a_oe = ALL_OFF;
        b_oe = ALL_OFF;
        unique case (mode)
            DRV_NONE: ;
            DRV_TO_A: a_oe = ALL_ON;
            DRV_TO_B: b_oe = ALL_ON;
            default:  ;
        endcase
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);

    logic             ab_fire;
    logic             ba_fire;
    logic [WIDTH-1:0] ab_q;
    logic [WIDTH-1:0] ba_q;

    xcvr_edge_fsm u_ab_edge (.clk(clk), .rst_n(rst_n), .strobe(cap_ab), .fire(ab_fire));
    xcvr_edge_fsm u_ba_edge (.clk(clk), .rst_n(rst_n), .strobe(cap_ba), .fire(ba_fire));

    xcvr_word_reg #(.WIDTH(WIDTH)) u_ab_reg (
        .clk(clk), .rst_n(rst_n), .load(ab_fire), .d(a_in), .q(ab_q)
    );
    xcvr_word_reg #(.WIDTH(WIDTH)) u_ba_reg (
        .clk(clk), .rst_n(rst_n), .load(ba_fire), .d(b_in), .q(ba_q)
    );

    xcvr_drive_ctl #(.WIDTH(WIDTH)) u_drive (
        .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
    );

    // Identical non-inverting lanes: source mux gated by the lane enable
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign b_out[i] = b_oe[i] & (sel_ab ? ab_q[i] : a_in[i]);
        assign a_out[i] = a_oe[i] & (sel_ba ? ba_q[i] : b_in[i]);
    end

    // R2
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ab_fire |=> ab_q == $past(a_in));

    // R3
    ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ba_fire |=> ba_q == $past(b_in));

    // R4
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_ab |=> $stable(ab_q));

    // R4
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_ba |=> $stable(ba_q));

    // R5
    isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    // R11
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|a_oe) && (|b_oe)));

    // R8
    live_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && dir && !sel_ab) |-> b_out == a_in);

    // R9
    stored_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir && sel_ba) |-> a_out == ba_q);

endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         oe_n = 1'b1, dir = 1'b0;
    logic         cap_ab = 1'b0, cap_ba = 1'b0;
    logic         sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cap_ab = 1'b0; cap_ba = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R1 stored A-to-B after reset", b_out, 8'h00);
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R1 stored B-to-A after reset", a_out, 8'h00);
    endtask

    task automatic t_capture_ab();
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; cap_ab = 1'b0;
        step();
        a_in = 8'hA5; cap_ab = 1'b1;
        step();
        a_in = 8'h3C; #1;
        chk("R2 stored A word", b_out, 8'hA5);
        chk("R6 b_oe on", b_oe, 8'hFF);
        chk("R6 a_oe off", a_oe, 8'h00);
        chk("R11 a_out zero when undriven", a_out, 8'h00);
        step();
        chk("R4 strobe held high keeps word", b_out, 8'hA5);
        cap_ab = 1'b0; step(); step();
        chk("R4 strobe held low keeps word", b_out, 8'hA5);
        sel_ab = 1'b0; #1;
        chk("R8 live A to B", b_out, 8'h3C);
        a_in = 8'h81; #1;
        chk("R8 live follows same cycle", b_out, 8'h81);
    endtask

    task automatic t_capture_ba();
        oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b1; cap_ba = 1'b0;
        step();
        b_in = 8'h69; cap_ba = 1'b1;
        step();
        b_in = 8'h12; cap_ba = 1'b0; #1;
        chk("R3 stored B word", a_out, 8'h69);
        chk("R7 a_oe on", a_oe, 8'hFF);
        chk("R7 b_oe off", b_oe, 8'h00);
        chk("R11 b_out zero when undriven", b_out, 8'h00);
        sel_ba = 1'b0; #1;
        chk("R9 live B to A", a_out, 8'h12);
    endtask

    task automatic t_isolation();
        oe_n = 1'b1; cap_ab = 1'b0; cap_ba = 1'b0; #1;
        chk("R5 a_oe off", a_oe, 8'h00);
        chk("R5 b_oe off", b_oe, 8'h00);
        chk("R5 a_out zero", a_out, 8'h00);
        chk("R5 b_out zero", b_out, 8'h00);
        step();
        a_in = 8'h5A; b_in = 8'hC3; cap_ab = 1'b1; cap_ba = 1'b1;
        step();
        cap_ab = 1'b0; cap_ba = 1'b0; a_in = 8'h00; b_in = 8'h00;
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R10 A capture during isolation", b_out, 8'h5A);
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R10 B capture during isolation", a_out, 8'hC3);
    endtask

    task automatic t_capture_driven_port();
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; cap_ba = 1'b0;
        step();
        b_in = 8'h77; cap_ba = 1'b1;
        step();
        cap_ba = 1'b0; b_in = 8'h00;
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R10 capture from driven port B", a_out, 8'h77);
    endtask

    task automatic t_high_through_reset();
        rst_n = 1'b0; cap_ab = 1'b1; a_in = 8'hEE;
        step();
        rst_n = 1'b1;
        step(); step();
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R1 reset cleared word", b_out, 8'h00);
        chk("R4 strobe high through reset stores nothing", b_out, 8'h00);
        cap_ab = 1'b0; step();
        cap_ab = 1'b1; step();
        cap_ab = 1'b0; #1;
        chk("R2 first edge after re-arm stores", b_out, 8'hEE);
    endtask

    initial begin
        t_reset();
        t_capture_ab();
        t_capture_ba();
        t_isolation();
        t_capture_driven_port();
        t_high_through_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule